// File: doc/BRIEF.md
# Binary-Field Montgomery Ladder Engine

This block runs the loop of a Montgomery-ladder scalar point multiplication on a binary elliptic curve over GF(2^M). It keeps the x-coordinates of two points in projective form, (X1:Z1) and (X2:Z2), and updates them once per scalar bit. Each update is one differential point addition and one point doubling. The engine takes a scalar, the affine x-coordinate of the base point and the curve coefficient b. When the last scalar bit has been handled, it presents the four projective values and pulses `done`. Conversion back to affine coordinates and recovery of y are left to a later stage.

There is no separate set-up phase. A start loads the fixed pair (1:0) into the first register pair and (xP:1) into the second. The first ladder step, on the leading 1 bit of the scalar, then turns these into (P, 2P) through the normal datapath. Three digit-serial field multipliers work in parallel, so a step costs two multiplier latencies. The scalar bit only selects which register pair is the addition target and which is the doubling target. The squarers and XOR adders are shared by both bit values.

Top module: `gf2m_ladder`

## Requirements
- R1: After reset, `done` is low and `x1_o`, `z1_o`, `x2_o` and `z2_o` are all zero.
- R2: A `start` accepted while idle captures `scalar`, `base_x` and `coef_b`. After that edge the outputs read X1=1, Z1=0, X2=`base_x`, Z2=1.
- R3: With the scalar's top bit at 1, the first step yields X1=xP, Z1=1, X2=xP^4+b, Z2=xP^2.
- R4: For a scalar bit of 1, one step sets Z1 to (X1·Z2+X2·Z1)^2 and X1 to xP·Z1new+(X1·Z2)(X2·Z1). It sets X2 to X2^4+b·Z2^4 and Z2 to X2^2·Z2^2, all from the old values.
- R5: For a scalar bit of 0, the step applies the R4 equations with the pairs (X1,Z1) and (X2,Z2) exchanged, both in the operands and in the results.
- R6: Scalar bits are consumed from bit KW-1 down to bit 0, one step each. The final outputs equal the ladder of R4/R5 started from the R2 values.
- R7: Field products are reduced modulo x^M + POLY. POLY holds the low M coefficients, with bit i standing for x^i. Field sums are a bitwise XOR. The result does not depend on the digit size D (1 ≤ D ≤ M).
- R8: `done` is high for exactly one cycle. The outputs then hold their values until the next accepted `start`.
- R9: A `start` that arrives while a run is in progress is ignored. The run in progress completes with its own result and latency, and no further run follows.
- R10: `done` rises exactly KW·(2·ceil(M/D)+4) clock edges after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run; acted on only while idle |
| scalar | input | KW | Scalar k, most significant bit expected to be 1 |
| base_x | input | M | Affine x-coordinate of the base point |
| coef_b | input | M | Curve coefficient b |
| x1_o | output | M | Projective X of the first ladder point |
| z1_o | output | M | Projective Z of the first ladder point |
| x2_o | output | M | Projective X of the second ladder point |
| z2_o | output | M | Projective Z of the second ladder point |
| done | output | 1 | One-cycle pulse when the run has finished |

## Verification
The bench builds two copies in GF(2^4) with polynomial x^4+x+1. The first has a four-bit scalar and three-bit digits, so the last digit of each product is a partial one. This small field allows a sweep over every base x, every b and every scalar with a leading one, and the results are compared with a shift-and-reduce ladder model. The second copy has a one-bit scalar and one-bit digits. It brings the forced first step out at the ports, where it is checked against the closed form in xP and b. The sweeps also check the exact latency for both digit sizes, the single-cycle `done`, and a start issued in the middle of a run.

// File: rtl/gf2m_ladder_pkg.sv
// Shared types for the binary-field ladder engine.
package gf2m_ladder_pkg;
    // Sequencer phases: issue stage 1, wait stage 1, issue stage 2, wait stage 2.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GO1   = 3'd1,
        ST_WAIT1 = 3'd2,
        ST_GO2   = 3'd3,
        ST_WAIT2 = 3'd4
    } seq_state_t;
endpackage

// File: rtl/gf2m_sqr.sv
// Combinational squarer in GF(2^M).
// Spreads the input bits to the even positions, then folds the upper half
// down using x^M = POLY. Assumes M >= 2.
module gf2m_sqr #(
    parameter int              M    = 163,
    parameter logic [M-1:0]    POLY = M'(8'hC9)
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] y
);
    localparam int WW = 2 * M - 1;

    logic [WW-1:0] wide;

    // Spread, then reduce from the top bit downward.
    always_comb begin
        wide = '0;
        for (int i = 0; i < M; i++) begin
            wide[2*i] = a[i];
        end
        for (int i = WW - 1; i >= M; i--) begin
            if (wide[i]) begin
                wide[i] = 1'b0;
                wide[i-M +: M] = wide[i-M +: M] ^ POLY;
            end
        end
        y = wide[M-1:0];
    end
endmodule

// File: rtl/gf2m_digit_mul.sv
// Least-significant-digit-first multiplier in GF(2^M).
// A one-cycle go pulse latches the operands. ceil(M/D) cycles later, done
// pulses for one cycle, and prod holds the product until the next go.
// Assumes 2 <= M and 1 <= D <= M.
module gf2m_digit_mul #(
    parameter int              M    = 163,
    parameter int              D    = 41,
    parameter logic [M-1:0]    POLY = M'(8'hC9)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [M-1:0] prod,
    output logic         done
);
    localparam int NDIG = (M + D - 1) / D;
    localparam int CW   = (NDIG > 1) ? $clog2(NDIG) : 1;

    logic [M-1:0]  a_r, b_r, acc;
    logic [M-1:0]  a_nx, acc_nx;
    logic [CW-1:0] cnt;
    logic          run;

    // Multiply by x modulo the field polynomial.
    function automatic logic [M-1:0] times_x(input logic [M-1:0] v);
        return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
    endfunction

    // Fold one digit of b into the accumulator while advancing a by x^D.
    always_comb begin
        acc_nx = acc;
        a_nx   = a_r;
        for (int j = 0; j < D; j++) begin
            if (b_r[j]) acc_nx = acc_nx ^ a_nx;
            a_nx = times_x(a_nx);
        end
    end

    // Operand capture, digit iteration and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r  <= '0;
            b_r  <= '0;
            acc  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                a_r <= a;
                b_r <= b;
                acc <= '0;
                cnt <= CW'(NDIG - 1);
                run <= 1'b1;
            end else if (run) begin
                acc <= acc_nx;
                a_r <= a_nx;
                b_r <= b_r >> D;
                if (cnt == '0) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    assign prod = acc;
endmodule

// File: rtl/gf2m_ladder_seq.sv
// Step sequencer for the ladder engine.
// Holds the scalar in a left-shifting register whose top bit is the
// current key bit. It runs two multiplier stages per bit and collects the
// done pulses of all multipliers before moving on. Starts are taken only
// while idle.
module gf2m_ladder_seq
    import gf2m_ladder_pkg::*;
#(
    parameter int KW   = 163,
    parameter int NMUL = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [KW-1:0]   scalar,
    input  logic [NMUL-1:0] mul_done,
    output logic            load,
    output logic            go,
    output logic            second,
    output logic            cap1,
    output logic            commit,
    output logic            kbit,
    output logic            busy,
    output logic            done
);
    localparam int CW = (KW > 1) ? $clog2(KW) : 1;

    seq_state_t      state;
    logic [KW-1:0]   ksr;
    logic [CW-1:0]   left;
    logic [NMUL-1:0] seen;
    logic            all_done;

    // Stage completes once every multiplier has reported, in any cycle.
    assign all_done = &(seen | mul_done);

    // Decoded strobes for the datapath.
    always_comb begin
        load   = (state == ST_IDLE) && start;
        go     = (state == ST_GO1) || (state == ST_GO2);
        second = (state == ST_GO2) || (state == ST_WAIT2);
        cap1   = (state == ST_WAIT1) && all_done;
        commit = (state == ST_WAIT2) && all_done;
        busy   = (state != ST_IDLE);
        kbit   = ksr[KW-1];
    end

    // Phase progression, scalar shifting and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ksr   <= '0;
            left  <= '0;
            seen  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ksr   <= scalar;
                        left  <= CW'(KW - 1);
                        state <= ST_GO1;
                    end
                end
                ST_GO1: begin
                    seen  <= '0;
                    state <= ST_WAIT1;
                end
                ST_WAIT1: begin
                    if (all_done) begin
                        seen  <= '0;
                        state <= ST_GO2;
                    end else begin
                        seen <= seen | mul_done;
                    end
                end
                ST_GO2: begin
                    seen  <= '0;
                    state <= ST_WAIT2;
                end
                ST_WAIT2: begin
                    if (all_done) begin
                        seen <= '0;
                        ksr  <= ksr << 1;
                        if (left == '0) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            left  <= left - 1'b1;
                            state <= ST_GO1;
                        end
                    end else begin
                        seen <= seen | mul_done;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gf2m_ladder.sv
// Montgomery ladder engine over GF(2^M), projective x-only coordinates.
// A start loads (1:0),(xP:1), and every scalar bit then performs one
// differential addition and one doubling on three shared multipliers.
// The key bit chooses which register pair acts as the addition target
// (A) and which as the doubling target (D).
// Assumes: POLY irreducible, 2 <= M, 1 <= D <= M, scalar[KW-1] = 1.
module gf2m_ladder
    import gf2m_ladder_pkg::*;
#(
    parameter int              M    = 163,
    parameter logic [M-1:0]    POLY = M'(8'hC9),
    parameter int              D    = 41,
    parameter int              KW   = 163
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [KW-1:0] scalar,
    input  logic [M-1:0]  base_x,
    input  logic [M-1:0]  coef_b,
    output logic [M-1:0]  x1_o,
    output logic [M-1:0]  z1_o,
    output logic [M-1:0]  x2_o,
    output logic [M-1:0]  z2_o,
    output logic          done
);
    localparam int           NMUL = 3;
    localparam logic [M-1:0] ONE  = M'(1);

    logic [M-1:0] x1, z1, x2, z2, xp_r, b_r;
    logic [M-1:0] p0, p1, p2;
    logic [M-1:0] ax, az, dx, dz;
    logic [M-1:0] sq_dx, sq_dz, dx4, dz4, za_new;
    logic [M-1:0] ax_n, az_n, dx_n, dz_n;
    logic [NMUL-1:0][M-1:0] opa, opb, prod;
    logic [NMUL-1:0]        mdone;
    logic load, go, second, cap1, commit, kbit, seq_busy;

    gf2m_ladder_seq #(.KW(KW), .NMUL(NMUL)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .scalar   (scalar),
        .mul_done (mdone),
        .load     (load),
        .go       (go),
        .second   (second),
        .cap1     (cap1),
        .commit   (commit),
        .kbit     (kbit),
        .busy     (seq_busy),
        .done     (done)
    );

    // Key-steered view of the register pairs: A is added into, D is doubled.
    always_comb begin
        ax = kbit ? x1 : x2;
        az = kbit ? z1 : z2;
        dx = kbit ? x2 : x1;
        dz = kbit ? z2 : z1;
    end

    gf2m_sqr #(.M(M), .POLY(POLY)) u_sq_dx  (.a(dx),      .y(sq_dx));
    gf2m_sqr #(.M(M), .POLY(POLY)) u_sq_dz  (.a(dz),      .y(sq_dz));
    gf2m_sqr #(.M(M), .POLY(POLY)) u_sq_dx4 (.a(sq_dx),   .y(dx4));
    gf2m_sqr #(.M(M), .POLY(POLY)) u_sq_dz4 (.a(sq_dz),   .y(dz4));
    gf2m_sqr #(.M(M), .POLY(POLY)) u_sq_za  (.a(p0 ^ p1), .y(za_new));

    // Multiplier operands: stage 1 cross products, stage 2 finishing terms.
    always_comb begin
        opa[0] = second ? xp_r : ax;
        opb[0] = second ? za_new : dz;
        opa[1] = second ? p0 : dx;
        opb[1] = second ? p1 : az;
        opa[2] = second ? b_r : sq_dx;
        opb[2] = second ? dz4 : sq_dz;
    end

    for (genvar g = 0; g < NMUL; g++) begin : g_mul
        gf2m_digit_mul #(.M(M), .D(D), .POLY(POLY)) u_mul (
            .clk   (clk),
            .rst_n (rst_n),
            .go    (go),
            .a     (opa[g]),
            .b     (opb[g]),
            .prod  (prod[g]),
            .done  (mdone[g])
        );
    end

    // New values of the addition and doubling targets.
    always_comb begin
        ax_n = prod[0] ^ prod[1];
        az_n = za_new;
        dx_n = dx4 ^ prod[2];
        dz_n = p2;
    end

    // Forced start values, stage 1 capture and key-steered write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x1 <= '0; z1 <= '0; x2 <= '0; z2 <= '0;
            xp_r <= '0; b_r <= '0;
            p0 <= '0; p1 <= '0; p2 <= '0;
        end else begin
            if (load) begin
                x1   <= ONE;
                z1   <= '0;
                x2   <= base_x;
                z2   <= ONE;
                xp_r <= base_x;
                b_r  <= coef_b;
            end
            if (cap1) begin
                p0 <= prod[0];
                p1 <= prod[1];
                p2 <= prod[2];
            end
            if (commit) begin
                if (kbit) begin
                    x1 <= ax_n; z1 <= az_n; x2 <= dx_n; z2 <= dz_n;
                end else begin
                    x2 <= ax_n; z2 <= az_n; x1 <= dx_n; z1 <= dz_n;
                end
            end
        end
    end

    assign x1_o = x1;
    assign z1_o = z1;
    assign x2_o = x2;
    assign z2_o = z2;
endmodule

// Protocol checks for the ladder engine, attached to every instance.
module gf2m_ladder_chk #(
    parameter int M = 163
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [M-1:0] base_x,
    input logic [M-1:0] x1,
    input logic [M-1:0] z1,
    input logic [M-1:0] x2,
    input logic [M-1:0] z2
);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (x1 == M'(1) && z1 == '0 && x2 == $past(base_x) && z2 == M'(1)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(x1) && $stable(z1) && $stable(x2) && $stable(z2)));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R6
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));
endmodule

bind gf2m_ladder gf2m_ladder_chk #(.M(M)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (seq_busy),
    .done   (done),
    .base_x (base_x),
    .x1     (x1_o),
    .z1     (z1_o),
    .x2     (x2_o),
    .z2     (z2_o)
);

// File: tb/gf2m_ladder_bench.sv
// Sweeps two small GF(2^4) engines against an arithmetic ladder model.
module gf2m_ladder_bench;
    localparam int           M  = 4;
    localparam logic [M-1:0] PL = 4'h3;   // x^4 + x + 1
    localparam int           KW = 4;
    localparam int LAT_A = KW * (2 * 2 + 4);  // D=3 -> 2 digits
    localparam int LAT_B = 1 * (2 * 4 + 4);   // D=1 -> 4 digits

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic st_a, st_b;
    logic [KW-1:0] key_a;
    logic [0:0]    key_b;
    logic [M-1:0]  xp_a, b_a, xp_b, b_b;
    logic [M-1:0]  x1a, z1a, x2a, z2a, x1b, z1b, x2b, z2b;
    logic done_a, done_b;

    int checks = 0;
    int bad = 0;
    int cyc = 0;

    gf2m_ladder #(.M(M), .POLY(PL), .D(3), .KW(KW)) u_gf2m_ladder (
        .clk(clk), .rst_n(rst_n), .start(st_a), .scalar(key_a),
        .base_x(xp_a), .coef_b(b_a),
        .x1_o(x1a), .z1_o(z1a), .x2_o(x2a), .z2_o(z2a), .done(done_a)
    );

    gf2m_ladder #(.M(M), .POLY(PL), .D(1), .KW(1)) u_gf2m_ladder_k1 (
        .clk(clk), .rst_n(rst_n), .start(st_b), .scalar(key_b),
        .base_x(xp_b), .coef_b(b_b),
        .x1_o(x1b), .z1_o(z1b), .x2_o(x2b), .z2_o(z2b), .done(done_b)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            bad++;
            $display("FAIL watchdog R6: actual=%0d cycles expected=<190000", cyc);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    // Full product then reduction by x^4+x+1.
    function automatic logic [3:0] bmul(input logic [3:0] a, input logic [3:0] b);
        logic [6:0] p;
        p = '0;
        for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (7'(a) << i);
        for (int i = 6; i >= 4; i--) if (p[i]) p = p ^ (7'h13 << (i - 4));
        return p[3:0];
    endfunction

    function automatic logic [3:0] bsq(input logic [3:0] a);
        return bmul(a, a);
    endfunction

    // Ladder written with explicit swap before and after each zero bit.
    task automatic ref_ladder(input logic [KW-1:0] k, input logic [3:0] xp,
                              input logic [3:0] b, output logic [15:0] res);
        logic [3:0] X1, Z1, X2, Z2, T;
        X1 = 4'd1; Z1 = 4'd0; X2 = xp; Z2 = 4'd1;
        for (int i = KW - 1; i >= 0; i--) begin
            if (!k[i]) begin T = X1; X1 = X2; X2 = T; T = Z1; Z1 = Z2; Z2 = T; end
            T  = Z1;
            Z1 = bsq(bmul(X1, Z2) ^ bmul(X2, Z1));
            X1 = bmul(xp, Z1) ^ bmul(bmul(X1, Z2), bmul(X2, T));
            T  = X2;
            X2 = bsq(bsq(X2)) ^ bmul(b, bsq(bsq(Z2)));
            Z2 = bmul(bsq(T), bsq(Z2));
            if (!k[i]) begin T = X1; X1 = X2; X2 = T; T = Z1; Z1 = Z2; Z2 = T; end
        end
        res = {X1, Z1, X2, Z2};
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One run on the four-bit-scalar engine, checking load, latency, result, hold.
    task automatic run_a(input logic [KW-1:0] k, input logic [3:0] xp, input logic [3:0] b);
        logic [15:0] exp;
        logic [15:0] got;
        int n;
        ref_ladder(k, xp, b, exp);
        @(negedge clk);
        key_a = k; xp_a = xp; b_a = b; st_a = 1'b1;
        @(negedge clk);
        st_a = 1'b0;
        check({x1a, z1a, x2a, z2a} == {4'd1, 4'd0, xp, 4'd1}, "R2 start load",
              {x1a, z1a, x2a, z2a}, {4'd1, 4'd0, xp, 4'd1});
        n = 0;
        while (!done_a && n < 500) begin @(negedge clk); n++; end
        check(n == LAT_A, "R10 latency D=3", n, LAT_A);
        got = {x1a, z1a, x2a, z2a};
        check(got == exp, "R4 R5 R6 R7 ladder result", got, exp);
        @(negedge clk);
        check(done_a == 1'b0, "R8 done width", done_a, 0);
        check({x1a, z1a, x2a, z2a} == got, "R8 hold after done", {x1a, z1a, x2a, z2a}, got);
    endtask

    // One run on the one-bit-scalar engine: the forced first step alone.
    task automatic run_b(input logic [3:0] xp, input logic [3:0] b);
        logic [15:0] exp;
        int n;
        exp = {xp, 4'd1, bsq(bsq(xp)) ^ b, bsq(xp)};
        @(negedge clk);
        key_b = 1'b1; xp_b = xp; b_b = b; st_b = 1'b1;
        @(negedge clk);
        st_b = 1'b0;
        n = 0;
        while (!done_b && n < 500) begin @(negedge clk); n++; end
        check(n == LAT_B, "R10 latency D=1", n, LAT_B);
        check({x1b, z1b, x2b, z2b} == exp, "R3 R7 first step", {x1b, z1b, x2b, z2b}, exp);
    endtask

    initial begin
        logic [15:0] exp9;
        int n;
        rst_n = 1'b0;
        st_a = 1'b0; st_b = 1'b0;
        key_a = '0; key_b = '0; xp_a = '0; b_a = '0; xp_b = '0; b_b = '0;
        repeat (3) @(negedge clk);
        check({done_a, x1a, z1a, x2a, z2a} == '0, "R1 reset A", {done_a, x1a, z1a, x2a, z2a}, 0);
        check({done_b, x1b, z1b, x2b, z2b} == '0, "R1 reset B", {done_b, x1b, z1b, x2b, z2b}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: every base x and b through the forced first step.
        for (int xp = 0; xp < 16; xp++)
            for (int b = 0; b < 16; b++)
                run_b(4'(xp), 4'(b));

        // R4 R5 R6: every scalar with leading one, every base x and b.
        for (int k = 8; k < 16; k++)
            for (int xp = 0; xp < 16; xp++)
                for (int b = 0; b < 16; b++)
                    run_a(4'(k), 4'(xp), 4'(b));

        // R9: a second start in mid-run is ignored.
        ref_ladder(4'b1011, 4'd5, 4'd9, exp9);
        @(negedge clk);
        key_a = 4'b1011; xp_a = 4'd5; b_a = 4'd9; st_a = 1'b1;
        @(negedge clk);
        st_a = 1'b0;
        n = 0;
        repeat (6) begin @(negedge clk); n++; end
        key_a = 4'b1100; xp_a = 4'd3; b_a = 4'd2; st_a = 1'b1;
        @(negedge clk);
        n++;
        st_a = 1'b0;
        while (!done_a && n < 500) begin @(negedge clk); n++; end
        check(n == LAT_A, "R9 latency unchanged", n, LAT_A);
        check({x1a, z1a, x2a, z2a} == exp9, "R9 result unchanged", {x1a, z1a, x2a, z2a}, exp9);
        n = 0;
        repeat (40) begin @(negedge clk); if (done_a) n++; end
        check(n == 0, "R9 no extra run", n, 0);
        check({x1a, z1a, x2a, z2a} == exp9, "R9 outputs held", {x1a, z1a, x2a, z2a}, exp9);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule